// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small fully associative store of taken-branch addresses that the fetch stage consults each cycle. The current fetch address is compared against every stored branch address with no clock in the path. The block reports whether the address is a known branch and whether it is predicted taken. It also gives the stored target and the address that fetch should use next. When a branch is found and its direction bit says taken, fetch is redirected to the target. In every other case fetch moves on to the sequential address.

Resolved branches come back through a valid/ready port that carries the branch address, the actual outcome and the actual target. A request is accepted on a clock edge where `rs_valid` and `rs_ready` are both high. The sender must hold the request stable until that edge. The write itself takes the following cycle, and `rs_ready` is low during that cycle, which pushes back on the next request. A taken branch that is not yet stored gets an entry. It goes into a free slot if one exists, and otherwise into the slot named by a round-robin pointer. A branch that is already stored has its target and direction bit rewritten.

Top module: `btb_unit`

## Requirements
- R1: `lk_hit` is high in the same cycle as `fetch_pc` exactly when a valid entry's stored address equals `fetch_pc`. On a hit, `lk_target` shows that entry's target.
- R2: `lk_taken` is high only on a hit whose direction bit is 1 (1 = taken, 0 = not taken). `next_pc` equals `lk_target` when `lk_taken` is high, and otherwise equals `fetch_pc + STEP` modulo 2^AW.
- R3: A resolved taken branch that is not stored creates an entry with its address, its target and direction bit 1.
- R4: A resolved not-taken branch that is not stored leaves the stored contents unchanged.
- R5: A resolved branch that is already stored overwrites that entry's target with the resolved target and sets its direction bit to the resolved outcome.
- R6: A new entry goes to the lowest-numbered invalid slot. When all slots are valid, it goes to the slot named by a pointer that starts at 0 after reset and advances by one, modulo DEPTH, on each such replacement.
- R7: `rs_ready` is high after reset and drops for exactly the one cycle that follows each accepted request. Results become visible to lookups from the cycle after that busy cycle.
- R8: During the busy cycle, a lookup of the address being written returns the contents from before the write.
- R9: A synchronous reset invalidates every entry and returns the round-robin pointer to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | AW | Address being fetched |
| lk_hit | output | AW>0 ? 1 : 1 | Address found in the buffer |
| lk_taken | output | 1 | Found and predicted taken |
| lk_target | output | AW | Stored target of the matching entry |
| next_pc | output | AW | Next fetch address |
| rs_valid | input | 1 | Resolve request present |
| rs_ready | output | 1 | Resolve port can accept |
| rs_pc | input | AW | Resolved branch address |
| rs_taken | input | 1 | Resolved outcome, 1 = taken |
| rs_target | input | AW | Resolved target address |

## Verification
The bench builds the block with AW = 8, DEPTH = 4 and STEP = 4. With these values the bench can sweep every one of the 256 possible fetch addresses after each resolve. It compares all four lookup outputs against a model of the table kept in the bench. Four slots fill after four taken branches, so several rounds of round-robin replacement fit in a short run. The 8-bit address makes the sequential increment wrap from 0xFC and above.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_UPDATE = 2'd1,
    WR_ALLOC  = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/btb_tag_match.sv
module btb_tag_match #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [AW-1:0]             key,
  input  logic [DEPTH-1:0]          vld,
  input  logic [DEPTH-1:0][AW-1:0]  tags,
  output logic                      hit,
  output logic [IW-1:0]             hit_idx
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (tags[g] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

  // R1
  one_match_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_vec));
endmodule

// File: rtl/btb_victim_sel.sv
module btb_victim_sel #(
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] vld,
  input  logic             advance,
  output logic [IW-1:0]    victim
);
  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_idx;
  logic          full;

  assign full = &vld;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IW'(i);
    end
  end

  assign victim = full ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (advance && full) rr_q <= (rr_q == IW'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
  end

  // R6
  rr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && full) |=> (rr_q == (($past(rr_q) == IW'(DEPTH - 1)) ? '0 : $past(rr_q) + 1'b1)));
  // R6
  rr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(advance && full) |=> $stable(rr_q));
endmodule

// File: rtl/btb_unit.sv
module btb_unit
  import btb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  parameter int STEP  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] fetch_pc,
  output logic          lk_hit,
  output logic          lk_taken,
  output logic [AW-1:0] lk_target,
  output logic [AW-1:0] next_pc,
  input  logic          rs_valid,
  output logic          rs_ready,
  input  logic [AW-1:0] rs_pc,
  input  logic          rs_taken,
  input  logic [AW-1:0] rs_target
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]         valid_q;
  logic [DEPTH-1:0][AW-1:0] tag_q;
  logic [DEPTH-1:0][AW-1:0] tgt_q;
  logic [DEPTH-1:0]         dir_q;

  logic          pend_q;
  logic [AW-1:0] p_pc;
  logic          p_tk;
  logic [AW-1:0] p_tgt;
  logic          accept;

  assign rs_ready = !pend_q;
  assign accept   = rs_valid && rs_ready;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= accept;
    if (accept) begin
      p_pc  <= rs_pc;
      p_tk  <= rs_taken;
      p_tgt <= rs_target;
    end
  end

  // Fetch-side lookup
  logic          f_hit;
  logic [IW-1:0] f_idx;

  btb_tag_match #(.AW(AW), .DEPTH(DEPTH)) u_fetch_match (
    .clk(clk), .rst(rst), .key(fetch_pc), .vld(valid_q), .tags(tag_q),
    .hit(f_hit), .hit_idx(f_idx)
  );

  assign lk_hit    = f_hit;
  assign lk_taken  = f_hit && dir_q[f_idx];
  assign lk_target = tgt_q[f_idx];
  assign next_pc   = lk_taken ? lk_target : fetch_pc + AW'(STEP);

  // Resolve-side write
  logic          w_hit;
  logic [IW-1:0] w_idx;
  logic [IW-1:0] victim;
  logic [IW-1:0] wr_idx;
  wr_kind_e      kind;

  btb_tag_match #(.AW(AW), .DEPTH(DEPTH)) u_write_match (
    .clk(clk), .rst(rst), .key(p_pc), .vld(valid_q), .tags(tag_q),
    .hit(w_hit), .hit_idx(w_idx)
  );

  always_comb begin
    if (!pend_q)    kind = WR_NONE;
    else if (w_hit) kind = WR_UPDATE;
    else if (p_tk)  kind = WR_ALLOC;
    else            kind = WR_NONE;
  end

  btb_victim_sel #(.DEPTH(DEPTH)) u_victim (
    .clk(clk), .rst(rst), .vld(valid_q), .advance(kind == WR_ALLOC), .victim(victim)
  );

  assign wr_idx = (kind == WR_UPDATE) ? w_idx : victim;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (kind != WR_NONE) begin
      valid_q[wr_idx] <= 1'b1;
      tag_q[wr_idx]   <= p_pc;
      tgt_q[wr_idx]   <= p_tgt;
      dir_q[wr_idx]   <= p_tk;
    end
  end

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_ready) |=> !rs_ready);
  // R7
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !rs_ready |=> rs_ready);
  // R2
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    lk_taken |-> lk_hit);
  // R4
  nt_miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !p_tk && !w_hit) |=> $stable(valid_q));
  // R3
  alloc_grows_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && p_tk && !w_hit && !(&valid_q)) |=> ($countones(valid_q) == $countones($past(valid_q)) + 1));
endmodule

// File: tb/btb_unit_tb.sv
`timescale 1ns/1ps
module btb_unit_tb;
  localparam int AW = 8;
  localparam int DEPTH = 4;
  localparam int STEP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] fetch_pc = '0;
  logic          lk_hit, lk_taken, rs_ready;
  logic [AW-1:0] lk_target, next_pc;
  logic          rs_valid = 1'b0;
  logic [AW-1:0] rs_pc = '0;
  logic          rs_taken = 1'b0;
  logic [AW-1:0] rs_target = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  btb_unit #(.AW(AW), .DEPTH(DEPTH), .STEP(STEP)) u_dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_target(lk_target), .next_pc(next_pc), .rs_valid(rs_valid), .rs_ready(rs_ready),
    .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target)
  );

  bit          m_v  [DEPTH];
  logic [AW-1:0] m_tag[DEPTH];
  logic [AW-1:0] m_tgt[DEPTH];
  bit          m_fl [DEPTH];
  int          m_rr;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    m_rr = 0;
  endtask

  task automatic model_write(input logic [AW-1:0] pc, input bit tk, input logic [AW-1:0] tg);
    int slot = -1;
    for (int i = 0; i < DEPTH; i++) if (m_v[i] && m_tag[i] == pc) slot = i;
    if (slot >= 0) begin
      m_tgt[slot] = tg; m_fl[slot] = tk;
    end else if (tk) begin
      for (int i = DEPTH - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % DEPTH; end
      m_v[slot] = 1; m_tag[slot] = pc; m_tgt[slot] = tg; m_fl[slot] = 1;
    end
  endtask

  task automatic probe(input logic [AW-1:0] pc, input string req);
    bit eh = 0, et = 0;
    logic [AW-1:0] eg = '0, en;
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && m_tag[i] == pc) begin eh = 1; et = m_fl[i]; eg = m_tgt[i]; end
    en = et ? eg : AW'(pc + STEP);
    fetch_pc = pc;
    #1;
    check((lk_hit == eh) && (lk_taken == et) && (next_pc == en) && (!eh || lk_target == eg), req,
          {pc, lk_hit, lk_taken, 6'd0, lk_target, next_pc},
          {pc, eh, et, 6'd0, eg, en});
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < (1 << AW); a++) probe(AW'(a), req);
  endtask

  task automatic resolve(input logic [AW-1:0] pc, input bit tk, input logic [AW-1:0] tg, input string req);
    @(negedge clk);
    check(rs_ready == 1'b1, "R7 ready before request", {31'd0, rs_ready}, 32'd1);
    rs_valid = 1; rs_pc = pc; rs_taken = tk; rs_target = tg;
    @(posedge clk);
    @(negedge clk);
    rs_valid = 0;
    #1;
    check(rs_ready == 1'b0, "R7 busy cycle", {31'd0, rs_ready}, 32'd0);
    probe(pc, "R8 old contents during write");
    @(posedge clk);
    @(negedge clk);
    #1;
    check(rs_ready == 1'b1, "R7 ready after busy", {31'd0, rs_ready}, 32'd1);
    model_write(pc, tk, tg);
    sweep(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_clear();
    #1;
    check(rs_ready == 1'b1, "R9 ready after reset", {31'd0, rs_ready}, 32'd1);
    sweep("R9 all entries cleared");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset();
    resolve(8'h10, 1, 8'hA0, "R3 allocate first taken");
    resolve(8'h30, 0, 8'h34, "R4 not-taken miss ignored");
    resolve(8'h20, 1, 8'hB0, "R3 allocate second taken");
    resolve(8'h10, 0, 8'h14, "R5 hit sets direction not taken");
    resolve(8'h10, 1, 8'hC4, "R5 hit rewrites target");
    resolve(8'hFC, 1, 8'h08, "R1 R2 high address entry");
    resolve(8'h40, 1, 8'h44, "R6 fill last free slot");
    resolve(8'h50, 0, 8'h00, "R4 miss when full not taken");
    resolve(8'h60, 1, 8'h64, "R6 replace slot 0");
    resolve(8'h70, 1, 8'h74, "R6 replace slot 1");
    resolve(8'h80, 1, 8'h84, "R6 replace slot 2");
    resolve(8'h90, 1, 8'h94, "R6 replace slot 3");
    resolve(8'hA0, 1, 8'h04, "R6 pointer wraps to slot 0");
    resolve(8'h70, 0, 8'h78, "R5 hit after replacement");
    do_reset();
    resolve(8'h33, 1, 8'h99, "R6 R9 slot 0 after reset");
    resolve(8'h44, 1, 8'h55, "R6 lowest free slot after reset");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule